// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block performs 32-bit integer multiplication and division one result bit per clock, running beside an integer pipeline that may itself be stalled. It holds a 64-bit result pair, HI and LO, and supports six operations on that pair: signed and unsigned multiply, signed and unsigned multiply-accumulate, and signed and unsigned multiply-subtract. Accumulate and subtract take the pair as it stands when the operation completes. A further multiply variant returns the low half of a signed product on a separate general-register result port and leaves the pair alone. Signed and unsigned divides put the quotient in LO and the remainder in HI.

A caller presents an opcode and two operands with `start`. While an operation runs, `busy` is high and further starts are refused, so the caller stalls. The number of busy cycles is exact and depends on the opcode and, for signed divide, on the operand signs. The pair can be written directly while the unit is idle. Either half can be read through a read port, which raises a stall flag instead of returning stale data while an operation is in flight.

Top module: `imdu_top`

## Requirements
- R1: Opcode encoding on `op`: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract, 6 signed multiply-to-register, 7 signed divide, 8 unsigned divide. A `start` with any other code while idle is ignored: `busy` stays low and HI/LO keep their values.
- R2: An accepted multiply (codes 0, 1) holds `busy` high for exactly 32 cycles after the start cycle. It then raises `done` for one cycle, with the 64-bit product in HI:LO (HI = upper half).
- R3: Multiply-to-register (code 6) takes 32 busy cycles. It raises `gpr_we` with `done` and presents the low 32 bits of the signed product on `gpr_result`. HI and LO are unchanged.
- R4: Multiply-add (codes 2, 3) adds the 64-bit product to the current HI:LO. Multiply-subtract (codes 4, 5) subtracts it. Both take exactly 34 busy cycles.
- R5: Divide writes the quotient (truncated toward zero) to LO and the remainder to HI. The remainder takes the sign of the dividend. Unsigned divide takes 33 busy cycles.
- R6: Signed divide takes 33 busy cycles when neither operand is negative, 34 when the divisor is negative, and 35 when only the dividend is negative.
- R7: A divide by zero completes after the busy count its operand signs select under R5/R6. It then raises `done` and returns to idle.
- R8: A `start` while `busy` is high is ignored. The running operation keeps its latency and result, and no second operation follows it.
- R9: With `hl_we` high while idle, `hl_wdata` is written to HI (`hl_sel`=1) or LO (`hl_sel`=0) at the clock edge. Writes while `busy` is high are ignored.
- R10: `rd_data` shows HI when `rd_sel`=1 and LO when `rd_sel`=0. `rd_stall` is high exactly when `rd_req` and `busy` are both high.
- R11: After reset, `busy`, `done` and `gpr_we` are low and HI and LO read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| op | input | 4 | Operation code (see R1) |
| opa | input | 32 | Multiplicand / dividend |
| opb | input | 32 | Multiplier / divisor |
| busy | output | 1 | Operation in progress; starts refused |
| done | output | 1 | One-cycle completion pulse |
| gpr_we | output | 1 | Multiply-to-register result valid |
| gpr_result | output | 32 | Multiply-to-register result |
| hl_we | input | 1 | Direct write enable for HI/LO |
| hl_sel | input | 1 | Write target: 1 HI, 0 LO |
| hl_wdata | input | 32 | Direct write data |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | Read source: 1 HI, 0 LO |
| rd_data | output | 32 | Selected HI or LO value |
| rd_stall | output | 1 | Read must wait: unit busy |

## Verification
Multiplies are driven with all-ones unsigned operands, which exercise every carry, and with mixed-sign and most-negative signed operands, which separate correct sign correction from magnitude-only products. Accumulate and subtract start from preset HI:LO values chosen so the result carries or borrows across the 32-bit halves. Divides cover all four sign combinations, which separate the 33/34/35-cycle paths and the quotient and remainder sign fixes, plus division by zero under each latency path. Stray starts, writes and reads issued mid-operation show that the running result and its timing are untouched.

// File: rtl/imdu_pkg.sv
package imdu_pkg;

  typedef enum logic [3:0] {
    OP_MULS = 4'd0,
    OP_MULU = 4'd1,
    OP_MACS = 4'd2,
    OP_MACU = 4'd3,
    OP_MSBS = 4'd4,
    OP_MSBU = 4'd5,
    OP_MULR = 4'd6,
    OP_DIVS = 4'd7,
    OP_DIVU = 4'd8
  } imdu_op_e;

  function automatic logic op_valid(input logic [3:0] op);
    return op <= 4'd8;
  endfunction

  function automatic logic op_signed(input logic [3:0] op);
    return (op == OP_MULS) || (op == OP_MACS) || (op == OP_MSBS) ||
           (op == OP_MULR) || (op == OP_DIVS);
  endfunction

  function automatic logic op_is_div(input logic [3:0] op);
    return (op == OP_DIVS) || (op == OP_DIVU);
  endfunction

  // busy-cycle count; w is the operand width (one iteration per bit)
  function automatic int unsigned op_latency(input logic [3:0] op,
                                             input logic a_neg,
                                             input logic b_neg,
                                             input int unsigned w);
    int unsigned l;
    case (op)
      OP_MACS, OP_MACU, OP_MSBS, OP_MSBU: l = w + 2;
      OP_DIVU: l = w + 1;
      OP_DIVS: begin
        if (b_neg)      l = w + 2;
        else if (a_neg) l = w + 3;
        else            l = w + 1;
      end
      default: l = w;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/imdu_seq.sv
module imdu_seq #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 4)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [CW-1:0] lat_in,
  output logic          busy,
  output logic          iter,
  output logic          fix,
  output logic          commit
);

  logic [CW-1:0] lat_q;
  logic [CW-1:0] elap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      elap  <= '0;
      lat_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      elap  <= '0;
      lat_q <= lat_in;
    end else if (busy) begin
      if (commit) busy <= 1'b0;
      else        elap <= elap + CW'(1);
    end
  end

  always_comb begin
    iter   = busy && (elap < CW'(W));
    commit = busy && (elap == lat_q - CW'(1));
    fix    = busy && !iter && !commit;
  end

  AST_ELAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> elap < lat_q);  // R2
  AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    busy && !commit |=> busy && (elap == $past(elap) + CW'(1)));  // R8
  AST_COMMIT_IDLES: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);  // R6

endmodule

// File: rtl/imdu_mul_core.sv
module imdu_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           fix,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod_q,
  output logic [2*W-1:0] res_now
);

  logic [W-1:0]   mcand;
  logic [2*W-1:0] prod;
  logic           neg;
  logic [W-1:0]   abs_a, abs_b;
  logic [W:0]     sum;
  logic [2*W-1:0] nxt;

  always_comb begin
    abs_a   = (sgn && a[W-1]) ? -a : a;
    abs_b   = (sgn && b[W-1]) ? -b : b;
    sum     = {1'b0, prod[2*W-1:W]} + {1'b0, mcand};
    nxt     = prod[0] ? {sum, prod[W-1:1]} : {1'b0, prod[2*W-1:1]};
    res_now = neg ? -nxt : nxt;
    prod_q  = prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand <= '0;
      prod  <= '0;
      neg   <= 1'b0;
    end else if (load) begin
      mcand <= abs_a;
      prod  <= {{W{1'b0}}, abs_b};
      neg   <= sgn && (a[W-1] ^ b[W-1]);
    end else if (step) begin
      prod <= nxt;
    end else if (fix && neg) begin
      prod <= -prod;
      neg  <= 1'b0;
    end
  end

  AST_MUL_FIX_SETTLES: assert property (@(posedge clk) disable iff (rst)
    fix && !load |=> !neg);  // R4

endmodule

// File: rtl/imdu_div_core.sv
module imdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         fix,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic [W-1:0] q, r, d;
  logic         negq, negr;
  logic [W:0]   r_sh, diff;
  logic         ge;
  logic [W-1:0] abs_a, abs_b;

  always_comb begin
    abs_a = (sgn && a[W-1]) ? -a : a;
    abs_b = (sgn && b[W-1]) ? -b : b;
    r_sh  = {r, q[W-1]};
    diff  = r_sh - {1'b0, d};
    ge    = !diff[W];
    quo   = q;
    rem   = r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      r    <= '0;
      d    <= '0;
      negq <= 1'b0;
      negr <= 1'b0;
    end else if (load) begin
      q    <= abs_a;
      r    <= '0;
      d    <= abs_b;
      negq <= sgn && (a[W-1] ^ b[W-1]);
      negr <= sgn && a[W-1];
    end else if (step) begin
      r <= ge ? diff[W-1:0] : r_sh[W-1:0];
      q <= {q[W-2:0], ge};
    end else if (fix) begin
      if (negq) begin
        q    <= -q;
        negq <= 1'b0;
      end else if (negr) begin
        r    <= -r;
        negr <= 1'b0;
      end
    end
  end

  AST_DIV_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    $past(step) && !$past(load) && (d != '0) && !fix |-> r < d);  // R5

endmodule

// File: rtl/imdu_top.sv
module imdu_top #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 4)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic         gpr_we,
  output logic [W-1:0] gpr_result,
  input  logic         hl_we,
  input  logic         hl_sel,
  input  logic [W-1:0] hl_wdata,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         rd_stall
);
  import imdu_pkg::*;

  logic           accept, sgn_in;
  logic [CW-1:0]  lat_in;
  logic           iter, fix, commit;
  logic [3:0]     op_q;
  logic           mul_load, div_load, mul_step, div_step, mul_fix, div_fix;
  logic [2*W-1:0] mul_prod, mul_now;
  logic [W-1:0]   quo, rem;
  logic [W-1:0]   hi_q, lo_q;
  logic [2*W-1:0] hilo;

  always_comb begin
    accept   = start && !busy && op_valid(op);
    sgn_in   = op_signed(op);
    lat_in   = CW'(op_latency(op, opa[W-1], opb[W-1], W));
    mul_load = accept && !op_is_div(op);
    div_load = accept && op_is_div(op);
    mul_step = iter && !op_is_div(op_q);
    div_step = iter && op_is_div(op_q);
    mul_fix  = fix && !op_is_div(op_q);
    div_fix  = fix && op_is_div(op_q);
    hilo     = {hi_q, lo_q};
    rd_data  = rd_sel ? hi_q : lo_q;
    rd_stall = rd_req && busy;
  end

  imdu_seq #(.W(W), .CW(CW)) seq_i (
    .clk(clk), .rst(rst), .accept(accept), .lat_in(lat_in),
    .busy(busy), .iter(iter), .fix(fix), .commit(commit)
  );

  imdu_mul_core #(.W(W)) mul_i (
    .clk(clk), .rst(rst), .load(mul_load), .step(mul_step), .fix(mul_fix),
    .sgn(sgn_in), .a(opa), .b(opb), .prod_q(mul_prod), .res_now(mul_now)
  );

  imdu_div_core #(.W(W)) div_i (
    .clk(clk), .rst(rst), .load(div_load), .step(div_step), .fix(div_fix),
    .sgn(sgn_in), .a(opa), .b(opb), .quo(quo), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) op_q <= '0;
    else if (accept) op_q <= op;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit) begin
      case (op_q)
        OP_MULS, OP_MULU: {hi_q, lo_q} <= mul_now;
        OP_MACS, OP_MACU: {hi_q, lo_q} <= hilo + mul_prod;
        OP_MSBS, OP_MSBU: {hi_q, lo_q} <= hilo - mul_prod;
        OP_DIVS, OP_DIVU: begin
          hi_q <= rem;
          lo_q <= quo;
        end
        default: ;
      endcase
    end else if (hl_we && !busy) begin
      if (hl_sel) hi_q <= hl_wdata;
      else        lo_q <= hl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      gpr_we     <= 1'b0;
      gpr_result <= '0;
    end else begin
      done   <= commit;
      gpr_we <= commit && (op_q == OP_MULR);
      if (commit && (op_q == OP_MULR)) gpr_result <= mul_now[W-1:0];
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R2
  AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && !commit |=> $stable(hi_q) && $stable(lo_q));  // R9
  AST_MULR_KEEPS_PAIR: assert property (@(posedge clk) disable iff (rst)
    commit && (op_q == OP_MULR) |=> $stable(hi_q) && $stable(lo_q));  // R3
  AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !op_valid(op) |=> !busy);  // R1
  AST_GPR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> done);  // R3

endmodule

// File: tb/imdu_top_tb_top.sv
module imdu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done, gpr_we, rd_stall;
  logic [31:0] gpr_result, rd_data;
  logic        hl_we = 1'b0, hl_sel = 1'b0, rd_req = 1'b0, rd_sel = 1'b0;
  logic [31:0] hl_wdata = '0;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  imdu_top dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .gpr_we(gpr_we), .gpr_result(gpr_result),
    .hl_we(hl_we), .hl_sel(hl_sel), .hl_wdata(hl_wdata),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .rd_stall(rd_stall)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_pair(output logic [31:0] hi, output logic [31:0] lo);
    rd_sel = 1'b1; #1 hi = rd_data;
    rd_sel = 1'b0; #1 lo = rd_data;
  endtask

  task automatic set_pair(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk); hl_we = 1'b1; hl_sel = 1'b1; hl_wdata = hi;
    @(negedge clk); hl_sel = 1'b0; hl_wdata = lo;
    @(negedge clk); hl_we = 1'b0;
  endtask

  // issues one operation, counts busy cycles, ends at the negedge of the done cycle
  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        output int lat, output logic dn,
                        output logic [31:0] hi, output logic [31:0] lo);
    @(negedge clk); start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk); start = 1'b0; lat = 0;
    while (busy && lat < 200) begin lat++; @(negedge clk); end
    dn = done;
    read_pair(hi, lo);
  endtask

  task automatic t_reset();
    logic [31:0] hi, lo;
    read_pair(hi, lo);
    chk("R11 busy", 64'(busy), 64'd0);
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 gpr_we", 64'(gpr_we), 64'd0);
    chk("R11 hilo", {hi, lo}, 64'd0);
  endtask

  task automatic t_mul(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    int lat; logic dn; logic [31:0] hi, lo; logic [63:0] e;
    if (o == 4'd0) e = 64'(longint'($signed(a)) * longint'($signed(b)));
    else           e = 64'(a) * 64'(b);
    run_op(o, a, b, lat, dn, hi, lo);
    chk("R2 mul latency", 64'(lat), 64'd32);
    chk("R2 mul done", 64'(dn), 64'd1);
    chk("R2 mul product", {hi, lo}, e);
    @(negedge clk);
    chk("R2 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_mulr();
    int lat; logic dn; logic [31:0] hi, lo;
    set_pair(32'h1234_5678, 32'h9abc_def0);
    run_op(4'd6, 32'hFFFF_FFFB, 32'd6, lat, dn, hi, lo);
    chk("R3 mulr latency", 64'(lat), 64'd32);
    chk("R3 gpr_we", 64'(gpr_we), 64'd1);
    chk("R3 gpr_result", 64'(gpr_result), 64'h0000_0000_FFFF_FFE2);
    chk("R3 hilo kept", {hi, lo}, 64'h1234_5678_9abc_def0);
  endtask

  task automatic t_mac(input logic [3:0] o, input logic [63:0] init,
                       input logic [31:0] a, input logic [31:0] b);
    int lat; logic dn; logic [31:0] hi, lo; logic [63:0] p, e;
    if (o == 4'd2 || o == 4'd4) p = 64'(longint'($signed(a)) * longint'($signed(b)));
    else                        p = 64'(a) * 64'(b);
    e = (o == 4'd2 || o == 4'd3) ? init + p : init - p;
    set_pair(init[63:32], init[31:0]);
    run_op(o, a, b, lat, dn, hi, lo);
    chk("R4 mac latency", 64'(lat), 64'd34);
    chk("R4 mac result", {hi, lo}, e);
  endtask

  task automatic t_div(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input int exp_lat);
    int lat; logic dn; logic [31:0] hi, lo, eq, er;
    if (o == 4'd7) begin
      eq = 32'($signed(a) / $signed(b));
      er = 32'($signed(a) % $signed(b));
    end else begin
      eq = a / b;
      er = a % b;
    end
    run_op(o, a, b, lat, dn, hi, lo);
    if (o == 4'd7) chk("R6 sdiv latency", 64'(lat), 64'(exp_lat));
    else           chk("R5 udiv latency", 64'(lat), 64'(exp_lat));
    chk("R5 quotient", 64'(lo), 64'(eq));
    chk("R5 remainder", 64'(hi), 64'(er));
  endtask

  task automatic t_div0(input logic [3:0] o, input logic [31:0] a, input int exp_lat);
    int lat; logic dn; logic [31:0] hi, lo;
    run_op(o, a, 32'd0, lat, dn, hi, lo);
    chk("R7 div0 latency", 64'(lat), 64'(exp_lat));
    chk("R7 div0 done", 64'(dn), 64'd1);
    @(negedge clk);
    chk("R7 div0 idle", 64'(busy), 64'd0);
  endtask

  task automatic t_start_busy();
    int lat; logic [31:0] hi, lo;
    @(negedge clk); start = 1'b1; op = 4'd1; opa = 32'd6; opb = 32'd7;
    @(negedge clk); start = 1'b0; lat = 0;
    while (busy && lat < 200) begin
      lat++;
      if (lat == 5) begin start = 1'b1; op = 4'd8; opa = 32'd1; opb = 32'd1; end
      if (lat == 6) start = 1'b0;
      @(negedge clk);
    end
    read_pair(hi, lo);
    chk("R8 latency kept", 64'(lat), 64'd32);
    chk("R8 result kept", {hi, lo}, 64'd42);
    @(negedge clk);
    chk("R8 no second op", 64'(busy), 64'd0);
  endtask

  task automatic t_busy_access();
    int lat; logic [31:0] hi, lo;
    set_pair(32'd0, 32'd0);
    @(negedge clk); start = 1'b1; op = 4'd1; opa = 32'd2; opb = 32'd3;
    @(negedge clk); start = 1'b0; lat = 0;
    hl_we = 1'b1; hl_sel = 1'b1; hl_wdata = 32'hDEAD_BEEF; rd_req = 1'b1;
    #1 chk("R10 stall while busy", 64'(rd_stall), 64'd1);
    while (busy && lat < 200) begin lat++; @(negedge clk); end
    hl_we = 1'b0;
    #1 chk("R10 no stall idle", 64'(rd_stall), 64'd0);
    rd_req = 1'b0;
    read_pair(hi, lo);
    chk("R9 busy write ignored", {hi, lo}, 64'd6);
  endtask

  task automatic t_idle_rw();
    logic [31:0] hi, lo;
    set_pair(32'hA5A5_0001, 32'h0F0F_0002);
    read_pair(hi, lo);
    chk("R9 write HI", 64'(hi), 64'h0000_0000_A5A5_0001);
    chk("R10 read LO", 64'(lo), 64'h0000_0000_0F0F_0002);
  endtask

  task automatic t_bad_op();
    logic [31:0] hi, lo;
    set_pair(32'h1111_2222, 32'h3333_4444);
    @(negedge clk); start = 1'b1; op = 4'hF; opa = 32'd9; opb = 32'd9;
    @(negedge clk); start = 1'b0;
    chk("R1 bad op not busy", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R1 bad op no done", 64'(done), 64'd0);
    read_pair(hi, lo);
    chk("R1 bad op pair kept", {hi, lo}, 64'h1111_2222_3333_4444);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_rw();
    t_bad_op();
    t_mul(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mul(4'd0, 32'hFFFF_FFFD, 32'd7);
    t_mul(4'd0, 32'h8000_0000, 32'h8000_0000);
    t_mul(4'd1, 32'h8000_0000, 32'd3);
    t_mulr();
    t_mac(4'd3, 64'h0000_0001_FFFF_FFF0, 32'h10, 32'h1);
    t_mac(4'd2, 64'h0000_0002_0000_0000, 32'd3, 32'hFFFF_FFFC);
    t_mac(4'd4, 64'h0000_0000_0000_0005, 32'hFFFF_FFFE, 32'd5);
    t_mac(4'd5, 64'h0000_0001_0000_0000, 32'h0001_0000, 32'h0001_0001);
    t_div(4'd8, 32'd100, 32'd7, 33);
    t_div(4'd8, 32'hFFFF_FFFF, 32'h10, 33);
    t_div(4'd7, 32'd100, 32'd7, 33);
    t_div(4'd7, 32'd100, 32'hFFFF_FFF9, 34);
    t_div(4'd7, 32'hFFFF_FF9C, 32'd7, 35);
    t_div(4'd7, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 34);
    t_div0(4'd8, 32'd5, 33);
    t_div0(4'd7, 32'd5, 33);
    t_div0(4'd7, 32'hFFFF_FFFB, 35);
    t_start_busy();
    t_busy_access();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule